// File: doc/BRIEF.md
# Single-Channel Bus-Request DMA Controller

This block moves a block of words between one I/O peripheral and system memory without the CPU touching the data. The CPU loads a start address and a word count through a small four-entry register port. It then writes a control word that selects the direction and the transfer mode and starts the block. The controller asks for the system bus with a request line and waits for the CPU's grant before it drives any memory or I/O strobe.

Each word moves in one bus cycle. A memory strobe and an I/O strobe are raised together, so the data passes straight from one side to the other and is never held inside the block. The peripheral paces the transfer through a request line and receives an acknowledge pulse for each word. In burst mode the controller keeps the bus until the whole block is done. In cycle-stealing mode it gives the bus back after every word and asks again for the next one. When the block completes, an interrupt stays raised until the CPU acknowledges it.

Top module: `dmac_top`

## Requirements
- R1: After reset, bus_req, irq, periph_ack and every strobe are low, and the address and count registers read back as zero.
- R2: Register select 0 is the address and 1 is the word count. Select 2 is control: write bit0 = go, bit1 = direction (0 peripheral-to-memory, 1 memory-to-peripheral), bit2 = cycle-steal mode. Control reads back bit0 = busy with bits 1 and 2 as written. Select 3 is status: bit0 = done, bit1 = busy.
- R3: While bus_grant is 1, register writes have no effect and reg_rdata reads 0.
- R4: A go with a nonzero count raises bus_req. No memory or I/O strobe is raised unless bus_grant and bus_req are both high.
- R5: A word moves in each cycle where bus_req, bus_grant and periph_req are all high, and periph_ack is high in that cycle. Direction 0 raises io_rd and mem_wr together. Direction 1 raises mem_rd and io_wr together.
- R6: mem_addr is the address register during a word move. After each word the address increments by one (modulo 2^16) and the count decrements by one. After a block, the address register holds start+N and the count holds 0.
- R7: In burst mode, bus_req stays high from the first grant until the last word, so the block uses exactly one bus request.
- R8: In cycle-steal mode, bus_req drops in the cycle after each word and rises again once bus_grant has fallen, so a block of N words uses N requests.
- R9: Completion sets done and raises irq while bus_req is low. irq stays high until the CPU reads status or writes 1 to status bit0.
- R10: A go with a count of zero sets done in the next cycle without ever raising bus_req.
- R11: While periph_req is low the transfer waits with the bus held. No word is lost or skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | CPU register write strobe |
| reg_rd | input | 1 | CPU register read strobe |
| reg_wdata | input | 16 | CPU write data |
| reg_rdata | output | 16 | CPU read data (zero unless reading with the bus held by the CPU) |
| bus_req | output | 1 | System bus request to the CPU |
| bus_grant | input | 1 | System bus grant from the CPU |
| mem_addr | output | 16 | Memory address during a word move |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| periph_req | input | 1 | Peripheral ready-for-word request |
| periph_ack | output | 1 | Word-moved acknowledge to the peripheral |
| irq | output | 1 | Block-complete interrupt |

## Verification
The transfer is tried with four block shapes that cover both directions in each mode. One of them starts two words below the top of the address space, so the address must wrap. Comparing the bus request count with the word count separates burst from cycle-steal behaviour, and the strobe pairing on each acknowledged word separates the two directions. Directed cases cover a zero-length block, a peripheral that holds back its request while the bus is granted, and register writes made while the grant is high.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ASK   = 2'd1,
    SEQ_YIELD = 2'd2
  } seq_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_STAT  = 2'd3;

  localparam int CTL_GO    = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_STEAL = 2;

  localparam int STS_DONE = 0;
  localparam int STS_BUSY = 1;
endpackage

// File: rtl/dmac_cursor.sv
`timescale 1ns/1ps
// Address and remaining-count registers, loaded by the CPU and stepped per word.
module dmac_cursor #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt,
  output logic              last,
  output logic              empty
);
  logic [ADDR_W-1:0] addr_d;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    addr_d = addr;
    cnt_d  = cnt;
    if (ld_addr) begin
      addr_d = addr_in;
    end else if (step) begin
      addr_d = addr + ADDR_W'(1);
    end
    if (ld_cnt) begin
      cnt_d = cnt_in;
    end else if (step) begin
      cnt_d = cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
    end else begin
      addr <= addr_d;
      cnt  <= cnt_d;
    end
  end

  assign last  = (cnt == CNT_W'(1));
  assign empty = (cnt == '0);
endmodule

// File: rtl/dmac_seq.sv
`timescale 1ns/1ps
// Bus handshake and word sequencing for burst and cycle-steal modes.
module dmac_seq
  import dmac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic steal,
  input  logic dir,
  input  logic empty,
  input  logic last,
  input  logic bus_grant,
  input  logic periph_req,
  output logic bus_req,
  output logic move,
  output logic finish,
  output logic busy,
  output logic mem_rd,
  output logic mem_wr,
  output logic io_rd,
  output logic io_wr
);
  seq_state_e st_q, st_d;

  assign move = (st_q == SEQ_ASK) && bus_grant && periph_req;

  always_comb begin
    st_d   = st_q;
    finish = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          if (empty) finish = 1'b1;
          else       st_d   = SEQ_ASK;
        end
      end
      SEQ_ASK: begin
        if (move) begin
          if (last) begin
            st_d   = SEQ_YIELD;
            finish = 1'b1;
          end else if (steal) begin
            st_d = SEQ_YIELD;
          end
        end
      end
      SEQ_YIELD: begin
        if (!bus_grant) st_d = empty ? SEQ_IDLE : SEQ_ASK;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  assign bus_req = (st_q == SEQ_ASK);
  assign busy    = (st_q != SEQ_IDLE);
  assign io_rd   = move && !dir;
  assign mem_wr  = move && !dir;
  assign mem_rd  = move && dir;
  assign io_wr   = move && dir;
endmodule

// File: rtl/dmac_top.sv
`timescale 1ns/1ps
module dmac_top
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  input  logic              periph_req,
  output logic              periph_ack,
  output logic              irq
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              busy, move, finish;
  logic              ld_addr, ld_cnt, ctl_wr, start, sts_clr, cpu_ok, wr_ok;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic              last, empty;
  logic              dir_q, dir_d, steal_q, steal_d, done_q, done_d;

  // The CPU owns the register port only while it holds the bus.
  assign cpu_ok  = !bus_grant;
  assign wr_ok   = reg_wr && cpu_ok && !busy;
  assign ld_addr = wr_ok && (reg_sel == SEL_ADDR);
  assign ld_cnt  = wr_ok && (reg_sel == SEL_COUNT);
  assign ctl_wr  = wr_ok && (reg_sel == SEL_CTRL);
  assign start   = ctl_wr && reg_wdata[CTL_GO];
  assign sts_clr = (reg_rd && cpu_ok && (reg_sel == SEL_STAT)) ||
                   (wr_ok && (reg_sel == SEL_STAT) && reg_wdata[STS_DONE]);

  always_comb begin
    dir_d   = dir_q;
    steal_d = steal_q;
    if (ctl_wr) begin
      dir_d   = reg_wdata[CTL_DIR];
      steal_d = reg_wdata[CTL_STEAL];
    end
    done_d = done_q;
    if (finish)       done_d = 1'b1;
    else if (sts_clr) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q   <= 1'b0;
      steal_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      dir_q   <= dir_d;
      steal_q <= steal_d;
      done_q  <= done_d;
    end
  end

  dmac_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cursor (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ld_addr (ld_addr),
    .ld_cnt  (ld_cnt),
    .addr_in (reg_wdata[ADDR_W-1:0]),
    .cnt_in  (reg_wdata[CNT_W-1:0]),
    .step    (move),
    .addr    (addr),
    .cnt     (cnt),
    .last    (last),
    .empty   (empty)
  );

  dmac_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .steal      (steal_q),
    .dir        (dir_q),
    .empty      (empty),
    .last       (last),
    .bus_grant  (bus_grant),
    .periph_req (periph_req),
    .bus_req    (bus_req),
    .move       (move),
    .finish     (finish),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .io_rd      (io_rd),
    .io_wr      (io_wr)
  );

  // Widen address and count to the register port.
  logic [REG_W-1:0] addr_ext, cnt_ext;
  generate
    if (REG_W > ADDR_W) begin : g_addr_pad
      assign addr_ext = {{(REG_W-ADDR_W){1'b0}}, addr};
    end else begin : g_addr_fit
      assign addr_ext = addr;
    end
    if (REG_W > CNT_W) begin : g_cnt_pad
      assign cnt_ext = {{(REG_W-CNT_W){1'b0}}, cnt};
    end else begin : g_cnt_fit
      assign cnt_ext = cnt;
    end
  endgenerate

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (reg_sel)
      SEL_ADDR:  rd_mux = addr_ext;
      SEL_COUNT: rd_mux = cnt_ext;
      SEL_CTRL: begin
        rd_mux[CTL_GO]    = busy;
        rd_mux[CTL_DIR]   = dir_q;
        rd_mux[CTL_STEAL] = steal_q;
      end
      SEL_STAT: begin
        rd_mux[STS_DONE] = done_q;
        rd_mux[STS_BUSY] = busy;
      end
      default: rd_mux = '0;
    endcase
    reg_rdata = (reg_rd && cpu_ok) ? rd_mux : '0;
  end

  assign mem_addr   = move ? addr : '0;
  assign periph_ack = move;
  assign irq        = done_q;
endmodule

// File: rtl/dmac_top_chk.sv
`timescale 1ns/1ps
module dmac_top_chk #(
  parameter int ADDR_W = 16,
  parameter int REG_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              periph_req,
  input logic              periph_ack,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              irq,
  input logic              steal_q,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [REG_W-1:0]  reg_rdata
);
  assert_strobe_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |-> (bus_grant && bus_req));

  assert_ack_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |-> (periph_req && bus_grant));

  assert_strobe_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |-> ((io_rd && mem_wr) != (mem_rd && io_wr)));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ack && $past(periph_ack)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && !steal_q) |-> irq);

  assert_steal_yield_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(periph_ack) && steal_q) |-> !bus_req);

  assert_irq_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req);

  assert_gate_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (reg_rdata == '0));
endmodule

bind dmac_top dmac_top_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .bus_req    (bus_req),
  .bus_grant  (bus_grant),
  .periph_req (periph_req),
  .periph_ack (periph_ack),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .irq        (irq),
  .steal_q    (steal_q),
  .mem_addr   (mem_addr),
  .reg_rdata  (reg_rdata)
);

// File: tb/test_dmac_top.sv
`timescale 1ns/1ps
module test_dmac_top;
  import dmac_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        bus_req;
  logic        bus_grant = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr;
  logic        periph_req = 1'b1;
  logic        periph_ack, irq;

  always #2.5 clk = ~clk;

  dmac_top i_dmac_top (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .periph_req(periph_req), .periph_ack(periph_ack), .irq(irq)
  );

  // CPU model: grant follows request one half-cycle later unless forced.
  logic auto_grant = 1'b1, grant_force = 1'b0;
  always @(negedge clk) bus_grant <= auto_grant ? bus_req : grant_force;

  int n_chk = 0, n_fail = 0;
  bit summary_done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
  endtask

  // Bus monitor, sampled after the falling edge once inputs have settled.
  int          acks = 0, rises = 0, strobe_err = 0, addr_err = 0;
  logic [15:0] exp_addr = 16'd0;
  logic        cur_dir = 1'b0, prev_req = 1'b0;
  initial forever begin
    @(negedge clk); #1;
    if (bus_req && !prev_req) rises++;
    prev_req = bus_req;
    if ((mem_rd | mem_wr | io_rd | io_wr) && !periph_ack) strobe_err++;
    if (periph_ack) begin
      acks++;
      if (!bus_grant) strobe_err++;
      if (cur_dir ? !(mem_rd && io_wr && !mem_wr && !io_rd)
                  : !(io_rd && mem_wr && !mem_rd && !io_wr)) strobe_err++;
      if (mem_addr !== exp_addr) addr_err++;
      exp_addr = exp_addr + 16'd1;
    end
  end

  task automatic cpu_wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] s, output logic [15:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic clear_mon(input logic [15:0] a, input logic d);
    acks = 0; rises = 0; strobe_err = 0; addr_err = 0; exp_addr = a; cur_dir = d;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!irq && t < 2000) begin @(negedge clk); t++; end
    check(req, {31'd0, irq}, 32'd1);
    repeat (3) @(negedge clk);
  endtask

  // {start address, word count, direction, cycle-steal}
  localparam logic [33:0] VEC [4] = '{
    {16'h1000, 16'd3, 1'b0, 1'b0},
    {16'h20FE, 16'd4, 1'b1, 1'b0},
    {16'hFFFE, 16'd3, 1'b0, 1'b1},
    {16'h0040, 16'd5, 1'b1, 1'b1}
  };

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 bus_req", {31'd0, bus_req}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 strobes", {28'd0, mem_rd, mem_wr, io_rd, io_wr}, 32'd0);
    cpu_rd(SEL_ADDR, rd);  check("R1 addr", {16'd0, rd}, 32'd0);
    cpu_rd(SEL_COUNT, rd); check("R1 count", {16'd0, rd}, 32'd0);

    // Main function: vector table
    for (int v = 0; v < 4; v++) begin
      logic [15:0] a, c;
      logic d, s;
      {a, c, d, s} = VEC[v];
      cpu_wr(SEL_ADDR, a);
      cpu_wr(SEL_COUNT, c);
      clear_mon(a, d);
      cpu_wr(SEL_CTRL, {13'd0, s, d, 1'b1});
      wait_done("R9 irq at completion");
      check("R5 word count", acks, {16'd0, c});
      check("R5 strobe pairing", strobe_err, 0);
      check("R6 address sequence", addr_err, 0);
      check(s ? "R8 requests per block" : "R7 requests per block", rises, s ? {16'd0, c} : 32'd1);
      check("R4 bus released", {31'd0, bus_req}, 32'd0);
      cpu_rd(SEL_ADDR, rd);  check("R6 final addr", {16'd0, rd}, {16'd0, a + c});
      cpu_rd(SEL_COUNT, rd); check("R6 final count", {16'd0, rd}, 32'd0);
      cpu_rd(SEL_CTRL, rd);  check("R2 control readback", {16'd0, rd}, {29'd0, s, d, 1'b0});
      cpu_rd(SEL_STAT, rd);  check("R2 status done", {16'd0, rd}, 32'd1);
      check("R9 irq cleared by read", {31'd0, irq}, 32'd0);
    end

    // R10 zero-length block
    cpu_wr(SEL_COUNT, 16'd0);
    clear_mon(16'd0, 1'b0);
    cpu_wr(SEL_CTRL, 16'h0001);
    check("R10 done next cycle", {31'd0, irq}, 32'd1);
    repeat (4) @(negedge clk);
    check("R10 no request", rises, 0);
    check("R10 no word", acks, 0);
    cpu_wr(SEL_STAT, 16'h0001);
    check("R9 irq cleared by write", {31'd0, irq}, 32'd0);

    // R11 peripheral holds back while the bus is granted
    periph_req = 1'b0;
    cpu_wr(SEL_ADDR, 16'h0300);
    cpu_wr(SEL_COUNT, 16'd2);
    clear_mon(16'h0300, 1'b0);
    cpu_wr(SEL_CTRL, 16'h0001);
    repeat (6) @(negedge clk);
    check("R11 no word while stalled", acks, 0);
    check("R11 bus held", {30'd0, bus_req, bus_grant}, 32'd3);
    check("R4 no strobe without periph", {28'd0, mem_rd, mem_wr, io_rd, io_wr}, 32'd0);
    reg_sel = SEL_ADDR; reg_rd = 1'b1; #1;
    check("R3 read gated by grant", {16'd0, reg_rdata}, 32'd0);
    @(negedge clk); reg_rd = 1'b0;
    periph_req = 1'b1;
    wait_done("R11 completes after stall");
    check("R11 all words", acks, 2);
    check("R11 address order", addr_err, 0);
    cpu_rd(SEL_STAT, rd);

    // R3 writes ignored while grant is high
    auto_grant = 1'b0; grant_force = 1'b1;
    @(negedge clk);
    cpu_wr(SEL_ADDR, 16'h5555);
    cpu_wr(SEL_CTRL, 16'h0001);
    check("R3 no start under grant", {31'd0, bus_req}, 32'd0);
    grant_force = 1'b0;
    @(negedge clk);
    auto_grant = 1'b1;
    cpu_rd(SEL_ADDR, rd);
    check("R3 addr write ignored", {16'd0, rd}, 32'h0302);

    summary();
    $finish;
  end
endmodule